// File: doc/BRIEF.md
# Ultra DMA Data-In Host Receiver

This block is the host end of an Ultra DMA read burst, where the drive sends data to the host. When it is enabled and the drive raises its DMA request, the block asserts its acknowledge. It waits out the envelope time and then releases STOP and asserts host-ready. While the burst runs, the three control lines take their burst meanings. The write-strobe line carries STOP, the read-strobe line carries host-ready (active low), and the ready line from the drive carries the drive strobe. Both edges of the drive strobe each deliver one 16-bit word. The block passes these words to a downstream consumer through a small FIFO with a valid/ready stream.

The drive strobe, drive data and DMA request are taken through a two-stage synchronizer into the system clock, so the drive strobe is oversampled. All protocol delays are system-clock counts. They are taken at burst start from a lookup that the 3-bit mode input selects.

The output stream follows the usual valid/ready rules. A word moves when `out_valid` and `out_ready` are both high at a rising clock edge. While `out_valid` is high and `out_ready` is low, `out_data` stays steady. Back-pressure never drops a word. Instead, a full buffer pauses the drive by negating host-ready, and the buffer keeps room for the words the drive may still send after the pause.

Top module: `udma_in_host`

## Requirements
- R1: After reset and whenever no burst is active, `host_ack_n`, `stop_line` and `host_rdy_n` are all 1 and `out_valid` is 0.
- R2: With `burst_en` low, a high `dev_req` does not start a burst. Toggling `dev_strobe` outside a burst produces no output word.
- R3: At burst start, `stop_line` and `host_rdy_n` both fall in the same cycle, exactly ENV cycles after `host_ack_n` falls. ENV is ceil(20 ns / CLK_NS), which is 4 at 5 ns.
- R4: Every transition of `dev_strobe` during a burst, rising or falling, captures the word on `dev_data`. The words leave on `out_data` in arrival order, with none lost or duplicated.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 with `out_data` unchanged.
- R6: When the buffer holds at least DEPTH-SKID-1 words (5 by default), `host_rdy_n` is 1 in the following cycle. The burst resumes (`host_rdy_n` goes to 0) once the level falls below that threshold and no stop is requested.
- R7: After host-ready is negated, SKID (2) further words from the drive are still accepted, without overflow and without loss.
- R8: With `stop_req` held, `stop_line` rises exactly RP cycles after `host_rdy_n` rises. RP is ceil(tRP / CLK_NS), with tRP equal to 160, 125, 100, 100 and 100 ns for modes 0 to 4. At 5 ns this gives 32, 25, 20, 20 and 20 cycles.
- R9: In a burst ended by the host, `host_ack_n` rises exactly ACK+4 cycles after `dev_req` falls. ACK is ceil(20 ns / CLK_NS). The extra cycles come from two synchronizer stages, one FSM decision and the sampling offset.
- R10: If `dev_req` falls during the transfer, `stop_line` and `host_rdy_n` rise, and `host_ack_n` rises exactly ACK cycles after `stop_line` rose.
- R11: Mode codes 5 to 7 use the mode-4 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Ultra DMA mode, sampled at burst start |
| burst_en | input | 1 | Allows a burst to start on a drive request |
| stop_req | input | 1 | Host request to end the current burst |
| dev_req | input | 1 | DMA request from the drive, active high |
| dev_strobe | input | 1 | Drive strobe (ready line during a burst) |
| dev_data | input | 16 | Drive data bus |
| host_ack_n | output | 1 | DMA acknowledge, active low |
| stop_line | output | 1 | Write-strobe line; high means STOP during a burst |
| host_rdy_n | output | 1 | Read-strobe line; low means host ready during a burst |
| out_valid | output | 1 | Output word available |
| out_data | output | 16 | Output word |
| out_ready | input | 1 | Consumer accepts the word |

## Verification
Two functions can fall in the same cycle. A strobe capture can land in the FIFO in the same cycle as a consumer pop. A stop request can also meet a pause that a full buffer has already caused. The bench covers both. It holds `out_ready` low until the drive model sees host-ready negate and pushes its two extra words. It then releases the consumer while captures are still arriving. Separately, it raises `stop_req` while the burst is running. The bench compares every word against its own arrival log, counts the pauses, and measures the cycle distance between line edges against the arithmetic counts for each mode.

// File: rtl/udma_in_pkg.sv
`timescale 1ns/1ps
package udma_in_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENV, ST_XFER, ST_PAUSE, ST_HALT, ST_ACKH
  } ust_e;

  typedef struct packed {
    logic [CNT_W-1:0] env;
    logic [CNT_W-1:0] rp;
    logic [CNT_W-1:0] ack;
  } utim_t;

  // round a nanosecond bound up to whole clock cycles
  function automatic logic [CNT_W-1:0] ns2cyc(input int ns, input int clk_ns);
    return CNT_W'((ns + clk_ns - 1) / clk_ns);
  endfunction
endpackage

// File: rtl/udma_in_sync.sv
`timescale 1ns/1ps
module udma_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/udma_in_timing.sv
`timescale 1ns/1ps
module udma_in_timing
  import udma_in_pkg::*;
#(
  parameter int CLK_NS = 5
) (
  input  logic [2:0] mode,
  output utim_t      tim
);
  localparam int ENV_NS = 20;
  localparam int ACK_NS = 20;

  always_comb begin
    tim.env = ns2cyc(ENV_NS, CLK_NS);
    tim.ack = ns2cyc(ACK_NS, CLK_NS);
    case (mode)
      3'd0:    tim.rp = ns2cyc(160, CLK_NS);
      3'd1:    tim.rp = ns2cyc(125, CLK_NS);
      default: tim.rp = ns2cyc(100, CLK_NS);
    endcase
  end
endmodule

// File: rtl/udma_in_fifo.sv
`timescale 1ns/1ps
module udma_in_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) if (do_push) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/udma_in_host.sv
`timescale 1ns/1ps
module udma_in_host
  import udma_in_pkg::*;
#(
  parameter int CLK_NS = 5,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int SKID   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          burst_en,
  input  logic          stop_req,
  input  logic          dev_req,
  input  logic          dev_strobe,
  input  logic [DW-1:0] dev_data,
  output logic          host_ack_n,
  output logic          stop_line,
  output logic          host_rdy_n,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int AW       = $clog2(DEPTH);
  localparam int PAUSE_AT = DEPTH - SKID - 1;
  localparam logic [AW:0] PAUSE_LVL = (AW+1)'(PAUSE_AT);

  ust_e             state;
  logic [CNT_W-1:0] cnt;
  utim_t            tim_lu, tim_q;
  logic             s_req, s_strb, strb_q;
  logic [DW-1:0]    s_data;
  logic             cap_push, fifo_empty, fifo_full, nearly_full, capturing;
  logic [AW:0]      fifo_level;

  udma_in_timing #(.CLK_NS(CLK_NS)) u_tim (
    .mode (mode > 3'd4 ? 3'd4 : mode),
    .tim  (tim_lu)
  );

  udma_in_sync #(.W(DW+2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dev_req, dev_strobe, dev_data}),
    .q     ({s_req, s_strb, s_data})
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= s_strb;

  assign capturing = (state == ST_XFER) || (state == ST_PAUSE) || (state == ST_HALT);
  assign cap_push  = capturing && s_req && (s_strb ^ strb_q);

  udma_in_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cap_push),
    .wdata (s_data),
    .pop   (out_ready),
    .rdata (out_data),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  assign out_valid   = !fifo_empty;
  assign nearly_full = (fifo_level >= PAUSE_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tim_q <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        ST_IDLE: if (burst_en && s_req) begin
          state <= ST_ENV;
          tim_q <= tim_lu;
          cnt   <= tim_lu.env - 1'b1;
        end
        ST_ENV: begin
          if (!s_req) begin
            state <= ST_ACKH; cnt <= tim_q.ack - 1'b1;
          end else if (cnt == '0) begin
            if (nearly_full || stop_req) begin
              state <= ST_PAUSE; cnt <= tim_q.rp - 1'b1;
            end else state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (!s_req) begin
            state <= ST_ACKH; cnt <= tim_q.ack - 1'b1;
          end else if (stop_req || nearly_full) begin
            state <= ST_PAUSE; cnt <= tim_q.rp - 1'b1;
          end
        end
        ST_PAUSE: begin
          if (!s_req) begin
            state <= ST_ACKH; cnt <= tim_q.ack - 1'b1;
          end else if (stop_req && cnt == '0) state <= ST_HALT;
          else if (!stop_req && !nearly_full) state <= ST_XFER;
        end
        ST_HALT: if (!s_req) begin
          state <= ST_ACKH; cnt <= tim_q.ack - 1'b1;
        end
        ST_ACKH: if (cnt == '0) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_ack_n = (state == ST_IDLE);
  assign stop_line  = (state == ST_IDLE) || (state == ST_ENV) ||
                      (state == ST_HALT) || (state == ST_ACKH);
  assign host_rdy_n = (state != ST_XFER);
endmodule

// File: rtl/udma_in_host_chk.sv
`timescale 1ns/1ps
module udma_in_host_chk
  import udma_in_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4,
  parameter int PAUSE_AT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_en,
  input logic          host_ack_n,
  input logic          stop_line,
  input logic          host_rdy_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          push,
  input logic          full,
  input logic [LW-1:0] level,
  input ust_e          state,
  input utim_t         tim_q
);
  logic [CNT_W-1:0] rdy_hi_cnt, stop_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_hi_cnt  <= '0;
      stop_hi_cnt <= '0;
    end else begin
      rdy_hi_cnt  <= !host_rdy_n ? '0 : (&rdy_hi_cnt  ? rdy_hi_cnt  : rdy_hi_cnt + 1'b1);
      stop_hi_cnt <= !stop_line  ? '0 : (&stop_hi_cnt ? stop_hi_cnt : stop_hi_cnt + 1'b1);
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack_n |-> (stop_line && host_rdy_n));

  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_en && host_ack_n) |=> host_ack_n);

  p_envelope_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack_n) |-> (stop_line && host_rdy_n));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= LW'(PAUSE_AT)) |=> host_rdy_n);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_rp_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && $past(state) == ST_PAUSE) |-> (rdy_hi_cnt >= tim_q.rp));

  p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack_n) |-> (stop_hi_cnt >= tim_q.ack));
endmodule

bind udma_in_host udma_in_host_chk #(
  .DW(DW), .LW($clog2(DEPTH)+1), .PAUSE_AT(DEPTH-SKID-1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_en   (burst_en),
  .host_ack_n (host_ack_n),
  .stop_line  (stop_line),
  .host_rdy_n (host_rdy_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .push       (cap_push),
  .full       (fifo_full),
  .level      (fifo_level),
  .state      (state),
  .tim_q      (tim_q)
);

// File: tb/test_udma_in_host.sv
`timescale 1ns/1ps
module test_udma_in_host;
  localparam int ACK = 4;
  localparam int ENV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, burst_en = 1'b0, stop_req = 1'b0, dev_req = 1'b0;
  logic dev_strobe = 1'b0, out_ready = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [15:0] dev_data = '0;
  logic host_ack_n, stop_line, host_rdy_n, out_valid;
  logic [15:0] out_data;

  udma_in_host i_udma_in_host (
    .clk(clk), .rst_n(rst_n), .mode(mode), .burst_en(burst_en),
    .stop_req(stop_req), .dev_req(dev_req), .dev_strobe(dev_strobe),
    .dev_data(dev_data), .host_ack_n(host_ack_n), .stop_line(stop_line),
    .host_rdy_n(host_rdy_n), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  int t_ack_fall, t_ack_rise, t_stop_fall, t_stop_rise, t_rdy_fall, t_rdy_rise;
  int pauses = 0;
  logic [15:0] exp_mem [0:1023];
  int exp_n = 0, rd_n = 0;
  logic p_ack = 1'b1, p_stop = 1'b1, p_rdy = 1'b1, p_stall = 1'b0;
  logic [15:0] p_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor and scoreboard, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ack && !host_ack_n)  t_ack_fall  = cyc;
      if (!p_ack && host_ack_n)  t_ack_rise  = cyc;
      if (p_stop && !stop_line)  t_stop_fall = cyc;
      if (!p_stop && stop_line)  t_stop_rise = cyc;
      if (p_rdy && !host_rdy_n)  t_rdy_fall  = cyc;
      if (!p_rdy && host_rdy_n) begin
        t_rdy_rise = cyc;
        if (!stop_line) pauses++;
      end
      if (p_stall) chk(out_valid && out_data == p_data, "R5 hold", int'(out_data), int'(p_data));
      if (out_valid && out_ready) begin
        chk(out_data == exp_mem[rd_n], "R4 order", int'(out_data), int'(exp_mem[rd_n]));
        rd_n++;
      end
      p_stall = out_valid && !out_ready;
      p_data  = out_data;
    end
    p_ack = host_ack_n; p_stop = stop_line; p_rdy = host_rdy_n;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] pat(input int i, input int m);
    return 16'((i * 2357) ^ (m << 13) ^ 16'h5A5A);
  endfunction

  task automatic send(input int per, input int m);
    logic [15:0] d;
    d = pat(exp_n, m);
    exp_mem[exp_n] = d;
    exp_n++;
    dev_data   = d;
    dev_strobe = ~dev_strobe;
    tick(per);
  endtask

  task automatic start_burst();
    dev_req = 1'b1;
    while (host_ack_n) tick(1);
    while (stop_line) tick(1);
    tick(1);
    chk(t_stop_fall - t_ack_fall == ENV, "R3 envelope", t_stop_fall - t_ack_fall, ENV);
    chk(t_rdy_fall == t_stop_fall, "R3 ready with stop", t_rdy_fall, t_stop_fall);
  endtask

  initial begin
    int per_tab [5] = '{24, 16, 12, 9, 6};
    int rp_tab  [5] = '{32, 25, 20, 20, 20};
    int c0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk(host_ack_n && stop_line && host_rdy_n && !out_valid, "R1 reset",
        {host_ack_n, stop_line, host_rdy_n, out_valid}, 4'b1110);

    for (int mi = 0; mi < 6; mi++) begin
      int eff, per, sent;
      eff  = (mi > 4) ? 4 : mi;
      mode = (mi == 5) ? 3'd7 : 3'(mi);   // R11 clamp case at mi == 5
      per  = per_tab[eff];
      burst_en = 1'b1;
      start_burst();

      // steady stream, consumer always ready (R4)
      out_ready = 1'b1;
      for (int k = 0; k < 10; k++) send(per, mi);
      tick(10);
      chk(rd_n == exp_n, "R4 stream count", rd_n, exp_n);

      // stalled consumer: pause, skid, resume (R6, R7)
      out_ready = 1'b0;
      pauses = 0;
      sent = 0;
      fork
        begin
          while (sent < 12) begin
            if (host_rdy_n) begin
              send(per, mi); send(per, mi); sent += 2;   // R7 skid words
              while (host_rdy_n) tick(1);
            end else begin
              send(per, mi); sent++;
            end
          end
        end
        begin
          tick(400);
          out_ready = 1'b1;
        end
      join
      tick(20);
      chk(pauses >= 1, "R6 pause seen", pauses, 1);
      chk(rd_n == exp_n, "R7 no loss after skid", rd_n, exp_n);
      chk(!host_rdy_n, "R6 resumed", host_rdy_n, 0);

      // host termination (R8, R9)
      stop_req = 1'b1;
      while (!stop_line) tick(1);
      tick(1);
      chk(t_stop_rise - t_rdy_rise == rp_tab[eff], "R8 stop wait",
          t_stop_rise - t_rdy_rise, rp_tab[eff]);
      dev_req = 1'b0;
      c0 = cyc;
      while (!host_ack_n) tick(1);
      tick(1);
      chk(t_ack_rise - c0 == ACK + 4, "R9 ack hold", t_ack_rise - c0, ACK + 4);
      chk(stop_line && host_rdy_n, "R1 idle lines", {stop_line, host_rdy_n}, 3);
      stop_req = 1'b0;
      tick(5);

      // drive termination (R10)
      start_burst();
      for (int k = 0; k < 3; k++) send(per, mi);
      dev_req = 1'b0;
      while (!host_ack_n) tick(1);
      tick(1);
      chk(t_ack_rise - t_stop_rise == ACK, "R10 device end", t_ack_rise - t_stop_rise, ACK);
      chk(rd_n == exp_n, "R10 words delivered", rd_n, exp_n);
      tick(5);
    end

    // disabled: request and strobes ignored (R2)
    burst_en = 1'b0;
    dev_req  = 1'b1;
    for (int k = 0; k < 6; k++) begin
      dev_data = 16'(k); dev_strobe = ~dev_strobe; tick(8);
    end
    chk(host_ack_n, "R2 no ack", host_ack_n, 1);
    chk(!out_valid, "R2 no words", out_valid, 0);
    chk(rd_n == exp_n, "R2 count", rd_n, exp_n);
    dev_req = 1'b0;
    tick(5);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end
endmodule